// File: doc/BRIEF.md
# PLL Lock Monitor

This block decides whether a phase-locked loop has settled by watching the up and down pulses of its phase frequency detector. A fast sampling clock measures how long exactly one of the two pulses is high during each comparison cycle. That count is the cycle's phase error in sampling ticks. The flag rises only after a run of consecutive cycles with small errors. It falls only when a single cycle shows an error larger than a wider clear limit, so the flag has hysteresis.

A precision input picks a tight or a loose set limit. A power-down input and a synchronous reset both clear all detection state. A second output is meant for pull-up style lock indication. It stays high while the loop is locked and drops low for each sampling tick that carries phase error. Both pulse inputs pass through a two-flop synchroniser before they are measured. All limits are parameters counted in sampling ticks.

Top module: `pll_lock_monitor`

## Requirements
- R1: `lock_o` goes high at the end of the fifth consecutive comparison cycle whose phase error is below the set limit (GOOD_CYCLES = 5). Four such cycles in a row leave it low. A cycle ends when `up_i | dn_i` falls.
- R2: With `fine_i` = 0 the set limit is SET_LOOSE_TICKS (10). With `fine_i` = 1 it is SET_TIGHT_TICKS (3). A cycle counts as good only if its error is strictly below the limit, so an error of 3 ticks is not good when `fine_i` = 1.
- R3: Once high, `lock_o` stays high until one cycle's error exceeds CLEAR_TICKS (25). An error of exactly 25 keeps it high, and an error of 26 clears it.
- R4: A cycle whose error is at or above the set limit but not above CLEAR_TICKS leaves `lock_o` unchanged and restarts the count of consecutive good cycles from zero.
- R5: While `pd` is high, `lock_o` is low and good cycles are not counted. After `pd` falls, five new good cycles are needed to set the flag.
- R6: A synchronous `rst` clears `lock_o`, `lock_pulse_o` and the good-cycle count.
- R7: Phase error is the number of sampling ticks in which exactly one of `up_i`, `dn_i` is high. Ticks in which both are high add nothing.
- R8: `lock_pulse_o` is low while unlocked. While locked it is high, except that it goes low for one tick per tick of phase error, so the number of low ticks in a cycle equals that cycle's error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| pd | input | 1 | Power-down, clears detection state, active high |
| up_i | input | 1 | Up pulse from the phase detector (asynchronous) |
| dn_i | input | 1 | Down pulse from the phase detector (asynchronous) |
| fine_i | input | 1 | Precision select: 0 loose set limit, 1 tight set limit |
| lock_o | output | 1 | Lock flag, active high |
| lock_pulse_o | output | 1 | High when locked, low for each phase-error tick |

## Verification
Directed comparison cycles place errors on each side of every limit: 9 and 10 ticks with loose precision, 2 and 3 ticks with tight precision, and 25 and 26 ticks against the clear limit. These separate strict from inclusive comparisons and the set limit from the clear limit. Runs broken by one middle-band cycle show that the good-cycle count restarts while the flag is held. Long overlap of both pulses shows that coincident activity is not counted as error. Random cycles mix leading and trailing error on either pulse, overlap length, precision and occasional power-down, and compare the flag to a model after every cycle.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_pair_t;

endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync
    import pll_lock_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  pfd_pair_t raw_i,
    output pfd_pair_t sync_o
);

    typedef struct packed {
        pfd_pair_t [STAGES-1:0] stg;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d        = state_q;
        state_d.stg[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            state_d.stg[i] = state_q.stg[i-1];
        end
        if (rst) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign sync_o = state_q.stg[STAGES-1];

endmodule

// File: rtl/pll_lock_err_meter.sv
module pll_lock_err_meter
    import pll_lock_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pd,
    input  pfd_pair_t        smp_i,
    output logic             eval_o,
    output logic [CNT_W-1:0] err_o,
    output logic             tick_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             act;
        logic [CNT_W-1:0] cnt;
    } meter_state_t;

    meter_state_t state_d, state_q;
    logic         act_now;
    logic         err_tick;

    always_comb begin
        act_now  = smp_i.up | smp_i.dn;
        err_tick = smp_i.up ^ smp_i.dn;
        eval_o   = state_q.act & ~act_now;

        state_d     = state_q;
        state_d.act = act_now;
        if (eval_o) begin
            state_d.cnt = '0;
        end else if (err_tick && (state_q.cnt != CNT_MAX)) begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
        if (rst || pd) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign err_o  = state_q.cnt;
    assign tick_o = err_tick;

endmodule

// File: rtl/pll_lock_decide.sv
module pll_lock_decide #(
    parameter int CNT_W           = 8,
    parameter int SET_LOOSE_TICKS = 10,
    parameter int SET_TIGHT_TICKS = 3,
    parameter int CLEAR_TICKS     = 25,
    parameter int GOOD_CYCLES     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pd,
    input  logic             fine_i,
    input  logic             eval_i,
    input  logic [CNT_W-1:0] err_i,
    input  logic             tick_i,
    output logic             good_o,
    output logic             lock_o,
    output logic             pulse_o
);

    localparam int               RUN_W     = $clog2(GOOD_CYCLES + 1);
    localparam logic [CNT_W-1:0] THR_LOOSE = CNT_W'(SET_LOOSE_TICKS);
    localparam logic [CNT_W-1:0] THR_TIGHT = CNT_W'(SET_TIGHT_TICKS);
    localparam logic [CNT_W-1:0] THR_CLEAR = CNT_W'(CLEAR_TICKS);
    localparam logic [RUN_W-1:0] RUN_FULL  = RUN_W'(GOOD_CYCLES);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             lock;
        logic             pulse;
    } decide_state_t;

    decide_state_t    state_d, state_q;
    logic [CNT_W-1:0] set_thr;
    logic             bad;
    logic [RUN_W-1:0] run_inc;

    always_comb begin
        set_thr = fine_i ? THR_TIGHT : THR_LOOSE;
        good_o  = err_i < set_thr;
        bad     = err_i > THR_CLEAR;
        run_inc = (state_q.run == RUN_FULL) ? state_q.run : state_q.run + 1'b1;

        state_d = state_q;
        if (eval_i) begin
            if (good_o) begin
                state_d.run = run_inc;
                if (run_inc == RUN_FULL) begin
                    state_d.lock = 1'b1;
                end
            end else begin
                state_d.run = '0;
                if (bad) begin
                    state_d.lock = 1'b0;
                end
            end
        end
        state_d.pulse = state_d.lock & ~tick_i;
        if (rst || pd) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign lock_o  = state_q.lock;
    assign pulse_o = state_q.pulse;

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
    import pll_lock_pkg::*;
#(
    parameter int CNT_W           = 8,
    parameter int SET_LOOSE_TICKS = 10,
    parameter int SET_TIGHT_TICKS = 3,
    parameter int CLEAR_TICKS     = 25,
    parameter int GOOD_CYCLES     = 5,
    parameter int SYNC_STAGES     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pd,
    input  logic up_i,
    input  logic dn_i,
    input  logic fine_i,
    output logic lock_o,
    output logic lock_pulse_o
);

    pfd_pair_t        raw_pair;
    pfd_pair_t        smp_pair;
    logic             cyc_eval;
    logic [CNT_W-1:0] cyc_err;
    logic             err_tick;
    logic             cyc_good;

    assign raw_pair.up = up_i;
    assign raw_pair.dn = dn_i;

    pll_lock_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (raw_pair),
        .sync_o (smp_pair)
    );

    pll_lock_err_meter #(
        .CNT_W (CNT_W)
    ) u_meter (
        .clk    (clk),
        .rst    (rst),
        .pd     (pd),
        .smp_i  (smp_pair),
        .eval_o (cyc_eval),
        .err_o  (cyc_err),
        .tick_o (err_tick)
    );

    pll_lock_decide #(
        .CNT_W           (CNT_W),
        .SET_LOOSE_TICKS (SET_LOOSE_TICKS),
        .SET_TIGHT_TICKS (SET_TIGHT_TICKS),
        .CLEAR_TICKS     (CLEAR_TICKS),
        .GOOD_CYCLES     (GOOD_CYCLES)
    ) u_decide (
        .clk     (clk),
        .rst     (rst),
        .pd      (pd),
        .fine_i  (fine_i),
        .eval_i  (cyc_eval),
        .err_i   (cyc_err),
        .tick_i  (err_tick),
        .good_o  (cyc_good),
        .lock_o  (lock_o),
        .pulse_o (lock_pulse_o)
    );

endmodule

// File: rtl/pll_lock_monitor_chk.sv
module pll_lock_monitor_chk #(
    parameter int CNT_W       = 8,
    parameter int CLEAR_TICKS = 25
) (
    input logic             clk,
    input logic             rst,
    input logic             pd,
    input logic             lock_o,
    input logic             lock_pulse_o,
    input logic             cyc_eval,
    input logic             cyc_good,
    input logic [CNT_W-1:0] cyc_err
);

    // R5: power-down drops the flag on the next edge
    assert_pd_clears_R5: assert property (@(posedge clk) disable iff (rst)
        pd |=> !lock_o);

    // R8: the pulse output is never high while unlocked
    assert_pulse_needs_lock_R8: assert property (@(posedge clk) disable iff (rst)
        lock_pulse_o |-> lock_o);

    // R1: the flag only rises after a good cycle was evaluated
    assert_rise_on_good_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_o) |-> ($past(cyc_eval) && $past(cyc_good)));

    // R3: the flag only falls on a cycle above the clear limit, or on power-down
    assert_fall_on_big_error_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(lock_o) && !$past(pd)) |-> ($past(cyc_eval) && (int'($past(cyc_err)) > CLEAR_TICKS)));

    // R4: the flag never moves between cycle boundaries
    assert_change_only_at_eval_R4: assert property (@(posedge clk) disable iff (rst)
        (!$stable(lock_o) && !$past(pd)) |-> $past(cyc_eval));

endmodule

bind pll_lock_monitor pll_lock_monitor_chk #(
    .CNT_W       (CNT_W),
    .CLEAR_TICKS (CLEAR_TICKS)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .pd           (pd),
    .lock_o       (lock_o),
    .lock_pulse_o (lock_pulse_o),
    .cyc_eval     (cyc_eval),
    .cyc_good     (cyc_good),
    .cyc_err      (cyc_err)
);

// File: tb/pll_lock_monitor_test.sv
module pll_lock_monitor_test;

    localparam int LOOSE = 10;
    localparam int TIGHT = 3;
    localparam int CLR   = 25;
    localparam int NGOOD = 5;
    localparam int GAP   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pd = 1'b0;
    logic up_i = 1'b0;
    logic dn_i = 1'b0;
    logic fine_i = 1'b0;
    logic lock_o;
    logic lock_pulse_o;

    int n_checks = 0;
    int n_fail = 0;
    int m_run = 0;
    bit m_lock = 1'b0;
    int low_cnt = 0;
    bit count_en = 1'b0;
    int cycles = 0;

    always #10 clk = ~clk;

    pll_lock_monitor uut (
        .clk          (clk),
        .rst          (rst),
        .pd           (pd),
        .up_i         (up_i),
        .dn_i         (dn_i),
        .fine_i       (fine_i),
        .lock_o       (lock_o),
        .lock_pulse_o (lock_pulse_o)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
            report();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int set_limit(input bit fine);
        return fine ? TIGHT : LOOSE;
    endfunction

    task automatic model_eval(input int err);
        if (pd) return;
        if (err < set_limit(fine_i)) begin
            if (m_run < NGOOD) m_run++;
            if (m_run == NGOOD) m_lock = 1'b1;
        end else begin
            m_run = 0;
            if (err > CLR) m_lock = 1'b0;
        end
    endtask

    task automatic tick(input bit u, input bit d);
        @(negedge clk);
        if (count_en && !lock_pulse_o) low_cnt++;
        up_i = u;
        dn_i = d;
    endtask

    // one comparison cycle: lead ticks on one pulse, overlap of both, tail on one
    task automatic cycle(input int lead, input bit lead_up, input int ovl,
                         input int tail, input bit tail_up, input string req);
        for (int i = 0; i < lead; i++) tick(lead_up, !lead_up);
        for (int i = 0; i < ovl; i++) tick(1'b1, 1'b1);
        for (int i = 0; i < tail; i++) tick(tail_up, !tail_up);
        for (int i = 0; i < GAP; i++) tick(1'b0, 1'b0);
        model_eval(lead + tail);
        @(negedge clk);
        check(lock_o == m_lock, req, lock_o, m_lock);
    endtask

    task automatic simple(input int err, input string req);
        cycle(err, 1'b1, 2, 0, 1'b0, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_run = 0;
        m_lock = 1'b0;
    endtask

    task automatic unlock();
        simple(CLR + 5, "R3");
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        check(lock_o == 1'b0, "R6 reset lock", lock_o, 0);
        check(lock_pulse_o == 1'b0, "R6 reset pulse", lock_pulse_o, 0);

        // R1 and R2 loose: error 9 is good
        fine_i = 1'b0;
        for (int k = 0; k < NGOOD; k++) simple(LOOSE - 1, "R1 five good cycles");
        check(lock_o == 1'b1, "R1 locked", lock_o, 1);

        // R3: exactly the clear limit keeps lock
        simple(CLR, "R3 error at clear limit");
        check(lock_o == 1'b1, "R3 held", lock_o, 1);

        // R8: middle-band error 12 keeps lock; low ticks equal error
        low_cnt = 0;
        count_en = 1'b1;
        cycle(7, 1'b0, 3, 5, 1'b1, "R4 middle band keeps lock");
        count_en = 1'b0;
        check(low_cnt == 12, "R8 low ticks per error", low_cnt, 12);

        simple(CLR + 1, "R3 error above clear limit");
        check(lock_o == 1'b0, "R3 cleared", lock_o, 0);
        check(lock_pulse_o == 1'b0, "R8 low when unlocked", lock_pulse_o, 0);

        // R2: loose limit is strict
        for (int k = 0; k < NGOOD; k++) simple(LOOSE, "R2 loose limit strict");
        check(lock_o == 1'b0, "R2 error 10 not good", lock_o, 0);

        // R2 tight: 3 not good, 2 good
        fine_i = 1'b1;
        for (int k = 0; k < NGOOD; k++) simple(TIGHT, "R2 tight limit strict");
        for (int k = 0; k < NGOOD; k++) simple(TIGHT - 1, "R2 tight good");
        check(lock_o == 1'b1, "R2 tight lock", lock_o, 1);
        unlock();

        // R4: run broken by a middle-band cycle restarts
        for (int k = 0; k < 3; k++) simple(1, "R4 pre-run");
        simple(5, "R4 breaker");
        for (int k = 0; k < NGOOD - 1; k++) simple(0, "R4 restarted run");
        check(lock_o == 1'b0, "R4 four after break", lock_o, 0);
        simple(0, "R4 fifth after break");
        check(lock_o == 1'b1, "R4 lock after restart", lock_o, 1);
        unlock();

        // R7: long overlap is not error
        fine_i = 1'b0;
        for (int k = 0; k < NGOOD; k++) cycle(1, 1'b1, 40, 1, 1'b0, "R7 overlap ignored");
        check(lock_o == 1'b1, "R7 lock with overlap", lock_o, 1);

        // R5: power-down clears and blocks counting
        @(negedge clk);
        pd = 1'b1;
        m_run = 0;
        m_lock = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(lock_o == 1'b0, "R5 pd clears", lock_o, 0);
        for (int k = 0; k < 3; k++) simple(0, "R5 counting blocked");
        pd = 1'b0;
        for (int k = 0; k < NGOOD - 1; k++) simple(0, "R5 after pd");
        check(lock_o == 1'b0, "R5 needs five after pd", lock_o, 0);
        simple(0, "R5 lock after pd");
        check(lock_o == 1'b1, "R5 relock", lock_o, 1);

        // R6: reset mid-run clears the count
        unlock();
        for (int k = 0; k < 3; k++) simple(0, "R6 pre-reset run");
        do_reset();
        for (int k = 0; k < 2; k++) simple(0, "R6 post-reset run");
        check(lock_o == 1'b0, "R6 count cleared", lock_o, 0);

        // random cycles
        void'($urandom(32'd1234));
        for (int k = 0; k < 400; k++) begin
            int lead, ovl, tail;
            lead = ($urandom % 4 == 0) ? $urandom % 30 : $urandom % 6;
            tail = $urandom % 4;
            ovl  = 1 + $urandom % 10;
            fine_i = $urandom % 3 == 0;
            if ($urandom % 40 == 0) begin
                @(negedge clk);
                pd = 1'b1;
                m_run = 0;
                m_lock = 1'b0;
                @(negedge clk);
                @(negedge clk);
                pd = 1'b0;
            end
            cycle(lead, $urandom % 2 == 0, ovl, tail, $urandom % 2 == 0, "R1 R3 random");
        end

        report();
    end

endmodule